// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block sits between dispatch and the memory pipelines of an out-of-order core. It keeps load operations and store operations in two separate slot pools and, in every cycle, decides which queued operations may be sent to execute, following a relaxed memory-ordering model. Operations that may touch memory and also carry side effects that are not modelled become barriers. A barrier holds a queue slot, may only execute once nothing older is left in its own pool, and holds back younger operations of the kind it fences until the execution unit reports that the barrier has completed.

Dispatch presents one operation per cycle with three flags: may read memory, may write memory, and has side effects. The block tells dispatch which slot of each pool the next operation will take, and whether either pool is full. For each slot it drives an issue-permission bit. The execution side reports completion by pool and slot, and the slot is freed. A static relax input lets loads overtake older ordinary stores, as when addresses are known not to overlap. Ordering between slots in different pools is kept by an age matrix: each slot records which other live slots were allocated before it.

Top module: `moq_order_queue`

## Requirements
- R1: Allocation flags map to slot kinds: read only gives a load; read with side effect gives a load barrier; write only, or read and write without side effect, gives a store; write with side effect gives a store barrier; read, write and side effect gives a full barrier. A request with neither read nor write allocates nothing.
- R2: A load whose only older live slots are loads has issue permission at once.
- R3: An ordinary store has issue permission only when no older slot of any kind is live in either pool, so at most one ordinary store holds permission at a time and stores issue in order.
- R4: With relax high, a load may hold permission while an older ordinary store is live; with relax low it may not. Relax is only changed while reset is asserted.
- R5: A load is held back by an older store or barrier that itself has an older live load, so loads do not reorder across an intervening store or barrier.
- R6: A load barrier gets permission only when no older slot is live in the load pool; younger loads stay blocked until it has completed.
- R7: A store barrier gets permission only when no older slot is live in the store pool; younger stores stay blocked until it has completed.
- R8: A full barrier takes one slot in each pool; both halves get permission in the same cycle, only when each half is oldest in its pool, and a completion reported for either half frees both.
- R9: The slot outputs name the lowest free slot of each pool; a full flag is high when no slot is free, and a request needing a full pool allocates nothing.
- R10: An accepted completion frees the slot, and all outputs reflect the new contents after the same clock edge that takes the completion or the allocation.
- R11: A completion for a slot that is empty or that does not hold issue permission is ignored.
- R12: A pool size parameter of zero selects the default depth of 8.
- R13: After reset both pools are empty, no permission bit is set, neither full flag is set and both slot outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| relax_ld_st | input | 1 | Static mode: loads may overtake older ordinary stores |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_may_load | input | 1 | Operation may read memory |
| alloc_may_store | input | 1 | Operation may write memory |
| alloc_side_effect | input | 1 | Operation has unmodelled side effects |
| alloc_ld_slot | output | LIW | Load pool slot the next allocation will take |
| alloc_st_slot | output | SIW | Store pool slot the next allocation will take |
| lq_full | output | 1 | Load pool has no free slot |
| sq_full | output | 1 | Store pool has no free slot |
| ld_issue_ok | output | LQD | Issue permission per load pool slot |
| st_issue_ok | output | SQD | Issue permission per store pool slot |
| done_valid | input | 1 | Completion report this cycle |
| done_is_store | input | 1 | Completion names the store pool (1) or the load pool (0) |
| done_slot | input | QIW | Slot index within the named pool |

## Verification
The assertions take for granted that relax_ld_st only moves while reset is high, and that the execution side reports at most one completion per cycle; they do not assume dispatch respects the full flags, since the block must drop such requests itself. The directed stimulus changes the relax mode only inside the reset task, offers allocations to full pools and completions to empty or unpermitted slots on purpose, and drains each pool through completions for slots whose permission the bench has first seen set.

// File: rtl/moq_pkg.sv
package moq_pkg;

  typedef enum logic [2:0] {
    K_LD = 3'd0,
    K_ST = 3'd1,
    K_LB = 3'd2,
    K_SB = 3'd3,
    K_FB = 3'd4
  } op_kind_e;

endpackage

// File: rtl/moq_free_pick.sv
module moq_free_pick #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);

  // lowest free slot wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end

endmodule

// File: rtl/moq_perm_logic.sv
module moq_perm_logic
  import moq_pkg::*;
#(
  parameter int LQD = 4,
  parameter int SQD = 4,
  parameter int N   = LQD + SQD,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]  vld,
  input  op_kind_e      kind  [N],
  input  logic [N-1:0]  older [N],
  input  logic [IW-1:0] pair  [N],
  input  logic          relax,
  output logic [N-1:0]  perm
);

  logic [N-1:0] lq_mask;   // slot belongs to load pool
  logic [N-1:0] ld_live;   // live ordinary loads
  logic [N-1:0] has_old_ld;// slot has an older live load
  logic [N-1:0] ld_block;  // slot blocks every younger load
  logic [N-1:0] own_old;   // slot is oldest in its own pool
  logic [N-1:0] same;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      lq_mask[j] = (j < LQD);
      ld_live[j] = vld[j] && (kind[j] == K_LD);
    end
    for (int j = 0; j < N; j++) begin
      has_old_ld[j] = |(older[j] & ld_live);
      ld_block[j]   = vld[j] && (
                        (kind[j] == K_LB) ||
                        (kind[j] == K_FB && lq_mask[j]) ||
                        (kind[j] == K_ST && !relax) ||
                        (kind[j] != K_LD && has_old_ld[j]));
    end
    same = '0;
    for (int i = 0; i < N; i++) begin
      same       = lq_mask[i] ? lq_mask : ~lq_mask;
      own_old[i] = ~|(older[i] & vld & same);
    end
    for (int i = 0; i < N; i++) begin
      perm[i] = 1'b0;
      if (vld[i]) begin
        case (kind[i])
          K_LD:    perm[i] = ~|(older[i] & ld_block);
          K_ST:    perm[i] = ~|(older[i] & vld);
          K_LB:    perm[i] = own_old[i];
          K_SB:    perm[i] = own_old[i];
          K_FB:    perm[i] = own_old[i] && own_old[pair[i]];
          default: perm[i] = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/moq_order_queue.sv
module moq_order_queue
  import moq_pkg::*;
#(
  parameter int LQ_SIZE   = 4,
  parameter int SQ_SIZE   = 4,
  parameter int DEF_DEPTH = 8,
  parameter int LQD = (LQ_SIZE == 0) ? DEF_DEPTH : LQ_SIZE,
  parameter int SQD = (SQ_SIZE == 0) ? DEF_DEPTH : SQ_SIZE,
  parameter int LIW = $clog2(LQD),
  parameter int SIW = $clog2(SQD),
  parameter int QIW = (LIW > SIW) ? LIW : SIW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           relax_ld_st,
  input  logic           alloc_valid,
  input  logic           alloc_may_load,
  input  logic           alloc_may_store,
  input  logic           alloc_side_effect,
  output logic [LIW-1:0] alloc_ld_slot,
  output logic [SIW-1:0] alloc_st_slot,
  output logic           lq_full,
  output logic           sq_full,
  output logic [LQD-1:0] ld_issue_ok,
  output logic [SQD-1:0] st_issue_ok,
  input  logic           done_valid,
  input  logic           done_is_store,
  input  logic [QIW-1:0] done_slot
);

  localparam int N  = LQD + SQD;
  localparam int IW = $clog2(N);

  // slot state
  logic [N-1:0]  vld_q, vld_d;
  op_kind_e      kind_q  [N];
  op_kind_e      kind_d  [N];
  logic [N-1:0]  older_q [N];
  logic [N-1:0]  older_d [N];
  logic [IW-1:0] pair_q  [N];
  logic [IW-1:0] pair_d  [N];
  logic [N-1:0]  perm_q, perm_d;

  logic           ld_found_q, st_found_q, ld_found_d, st_found_d;
  logic [LIW-1:0] ld_slot_q, ld_slot_d;
  logic [SIW-1:0] st_slot_q, st_slot_d;

  // allocation decode
  logic     need_lq, need_sq, alloc_ok;
  op_kind_e k_lq, k_sq;
  logic [IW-1:0] g_lq, g_sq;

  always_comb begin
    need_lq = alloc_valid && alloc_may_load && (alloc_side_effect || !alloc_may_store);
    need_sq = alloc_valid && alloc_may_store;
    k_lq    = alloc_side_effect ? (alloc_may_store ? K_FB : K_LB) : K_LD;
    k_sq    = alloc_side_effect ? (alloc_may_load  ? K_FB : K_SB) : K_ST;
    alloc_ok = (need_lq || need_sq) &&
               (!need_lq || ld_found_q) && (!need_sq || st_found_q);
    g_lq    = IW'(ld_slot_q);
    g_sq    = IW'(LQD) + IW'(st_slot_q);
  end

  // completion decode
  logic          done_inrange, done_acc;
  logic [IW-1:0] g_done;
  logic [N-1:0]  free_mask;

  always_comb begin
    done_inrange = done_is_store ? (int'(done_slot) < SQD) : (int'(done_slot) < LQD);
    g_done       = '0;
    if (done_inrange)
      g_done = done_is_store ? (IW'(LQD) + IW'(done_slot)) : IW'(done_slot);
    done_acc  = done_valid && done_inrange && vld_q[g_done] && perm_q[g_done];
    free_mask = '0;
    if (done_acc) begin
      free_mask[g_done] = 1'b1;
      if (kind_q[g_done] == K_FB) free_mask[pair_q[g_done]] = 1'b1;
    end
  end

  // next state
  always_comb begin
    vld_d = vld_q & ~free_mask;
    for (int i = 0; i < N; i++) begin
      kind_d[i]  = kind_q[i];
      pair_d[i]  = pair_q[i];
      older_d[i] = older_q[i] & ~free_mask;
    end
    if (alloc_ok) begin
      if (need_lq) begin
        kind_d[g_lq]  = k_lq;
        older_d[g_lq] = vld_q & ~free_mask;
        pair_d[g_lq]  = g_sq;
      end
      if (need_sq) begin
        kind_d[g_sq]  = k_sq;
        older_d[g_sq] = vld_q & ~free_mask;
        pair_d[g_sq]  = g_lq;
      end
      if (need_lq) vld_d[g_lq] = 1'b1;
      if (need_sq) vld_d[g_sq] = 1'b1;
    end
  end

  moq_perm_logic #(.LQD(LQD), .SQD(SQD), .N(N), .IW(IW)) u_perm (
    .vld   (vld_d),
    .kind  (kind_d),
    .older (older_d),
    .pair  (pair_d),
    .relax (relax_ld_st),
    .perm  (perm_d)
  );

  moq_free_pick #(.W(LQD), .IW(LIW)) u_ld_pick (
    .busy  (vld_d[LQD-1:0]),
    .found (ld_found_d),
    .idx   (ld_slot_d)
  );

  moq_free_pick #(.W(SQD), .IW(SIW)) u_st_pick (
    .busy  (vld_d[N-1:LQD]),
    .found (st_found_d),
    .idx   (st_slot_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      perm_q     <= '0;
      ld_found_q <= 1'b1;
      st_found_q <= 1'b1;
      ld_slot_q  <= '0;
      st_slot_q  <= '0;
      for (int i = 0; i < N; i++) begin
        kind_q[i]  <= K_LD;
        older_q[i] <= '0;
        pair_q[i]  <= '0;
      end
    end else begin
      vld_q      <= vld_d;
      perm_q     <= perm_d;
      ld_found_q <= ld_found_d;
      st_found_q <= st_found_d;
      ld_slot_q  <= ld_slot_d;
      st_slot_q  <= st_slot_d;
      for (int i = 0; i < N; i++) begin
        kind_q[i]  <= kind_d[i];
        older_q[i] <= older_d[i];
        pair_q[i]  <= pair_d[i];
      end
    end
  end

  assign alloc_ld_slot = ld_slot_q;
  assign alloc_st_slot = st_slot_q;
  assign lq_full       = !ld_found_q;
  assign sq_full       = !st_found_q;
  assign ld_issue_ok   = perm_q[LQD-1:0];
  assign st_issue_ok   = perm_q[N-1:LQD];

  // ---------------- assertions ----------------
  logic [N-1:0] st_kind_mask;
  always_comb begin
    for (int i = 0; i < N; i++) st_kind_mask[i] = vld_q[i] && (kind_q[i] == K_ST);
  end

  // R3: ordinary stores are granted one at a time
  a_r3_one_store: assert property (@(posedge clk) disable iff (rst)
    $onehot0(perm_q & st_kind_mask));

  // R4: relax mode is static outside reset
  a_r4_relax_static: assert property (@(posedge clk) disable iff (rst)
    $stable(relax_ld_st));

  // R9: a full load pool stays full without a completion
  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (lq_full && !done_valid) |=> lq_full);

  // R10: accepted completion frees the slot
  a_r10_done_frees: assert property (@(posedge clk) disable iff (rst)
    done_acc |=> !vld_q[$past(g_done)]);

  // R11: completion without permission leaves a live slot in place
  a_r11_done_ignored: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_inrange && vld_q[g_done] && !perm_q[g_done])
      |=> vld_q[$past(g_done)]);

  // R8: both halves of a full barrier are granted together
  for (genvar gi = 0; gi < N; gi++) begin : g_fb_chk
    a_r8_fb_pair: assert property (@(posedge clk) disable iff (rst)
      (vld_q[gi] && kind_q[gi] == K_FB) |-> (perm_q[gi] == perm_q[pair_q[gi]]));
  end

endmodule

// File: tb/sim_moq_order_queue.sv
module sim_moq_order_queue;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic relax = 1'b1;
  logic a_v = 1'b0, a_ld = 1'b0, a_st = 1'b0, a_se = 1'b0;
  logic d_v = 1'b0, d_st = 1'b0;
  logic [2:0] d_slot = '0;

  logic [1:0] ld_slot0, st_slot0;
  logic       lqf0, sqf0;
  logic [3:0] ldok0, stok0;
  logic [2:0] ld_slot1, st_slot1;
  logic       lqf1, sqf1;
  logic [7:0] ldok1, stok1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  moq_order_queue #(.LQ_SIZE(4), .SQ_SIZE(4)) u0 (
    .clk(clk), .rst(rst), .relax_ld_st(relax),
    .alloc_valid(a_v), .alloc_may_load(a_ld), .alloc_may_store(a_st),
    .alloc_side_effect(a_se),
    .alloc_ld_slot(ld_slot0), .alloc_st_slot(st_slot0),
    .lq_full(lqf0), .sq_full(sqf0),
    .ld_issue_ok(ldok0), .st_issue_ok(stok0),
    .done_valid(d_v), .done_is_store(d_st), .done_slot(d_slot[1:0])
  );

  moq_order_queue #(.LQ_SIZE(0), .SQ_SIZE(0)) u1 (
    .clk(clk), .rst(rst), .relax_ld_st(relax),
    .alloc_valid(a_v), .alloc_may_load(a_ld), .alloc_may_store(a_st),
    .alloc_side_effect(a_se),
    .alloc_ld_slot(ld_slot1), .alloc_st_slot(st_slot1),
    .lq_full(lqf1), .sq_full(sqf1),
    .ld_issue_ok(ldok1), .st_issue_ok(stok1),
    .done_valid(d_v), .done_is_store(d_st), .done_slot(d_slot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic rx);
    rst = 1'b1;
    relax = rx;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic alloc(input logic l, input logic s, input logic e);
    a_v = 1'b1; a_ld = l; a_st = s; a_se = e;
    @(negedge clk);
    a_v = 1'b0; a_ld = 1'b0; a_st = 1'b0; a_se = 1'b0;
  endtask

  task automatic done(input logic is_st, input int slot);
    d_v = 1'b1; d_st = is_st; d_slot = 3'(slot);
    @(negedge clk);
    d_v = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    chk("R13", "ld_issue", int'(ldok0), 0);
    chk("R13", "st_issue", int'(stok0), 0);
    chk("R13", "full flags", int'({lqf0, sqf0}), 0);
    chk("R13", "slots", int'({ld_slot0, st_slot0}), 0);
  endtask

  task automatic t_kinds;
    do_reset(1'b1);
    alloc(1, 1, 0);               // R1 read+write, no side effect -> store
    chk("R1", "rw no se st_issue", int'(stok0), 1);
    chk("R1", "rw no se ld_issue", int'(ldok0), 0);
    chk("R1", "rw no se ld slot", int'(ld_slot0), 0);
    alloc(0, 0, 1);               // R1 no read, no write -> nothing
    chk("R1", "empty req st slot", int'(st_slot0), 1);
    chk("R1", "empty req ld slot", int'(ld_slot0), 0);
    alloc(1, 0, 1);               // R1 load barrier, oldest in load pool
    chk("R1", "load barrier grant", int'(ldok0), 1);
  endtask

  task automatic t_load_pass;
    do_reset(1'b0);
    alloc(1, 0, 0);
    alloc(1, 0, 0);
    chk("R2", "two loads granted", int'(ldok0), 3);
  endtask

  task automatic t_store_order;
    do_reset(1'b1);
    alloc(0, 1, 0);
    alloc(0, 1, 0);
    chk("R3", "only oldest store", int'(stok0), 1);
    done(1, 0);
    chk("R3", "next store after done", int'(stok0), 2);
    do_reset(1'b1);
    alloc(1, 0, 0);
    alloc(0, 1, 0);
    chk("R3", "store behind load", int'(stok0), 0);
    done(0, 0);
    chk("R3", "store after load done", int'(stok0), 1);
  endtask

  task automatic t_relax;
    do_reset(1'b0);
    alloc(0, 1, 0);
    alloc(1, 0, 0);
    chk("R4", "strict load blocked", int'(ldok0), 0);
    do_reset(1'b1);
    alloc(0, 1, 0);
    alloc(1, 0, 0);
    chk("R4", "relaxed load passes", int'(ldok0), 1);
  endtask

  task automatic t_store_between;
    do_reset(1'b1);
    alloc(1, 0, 0);   // ld0
    alloc(0, 1, 0);   // st0
    alloc(1, 0, 0);   // ld1
    chk("R5", "load across store", int'(ldok0), 1);
    done(0, 0);
    chk("R5", "load free after ld0", int'(ldok0), 2);
    chk("R5", "store free after ld0", int'(stok0), 1);
  endtask

  task automatic t_ld_barrier;
    do_reset(1'b1);
    alloc(1, 0, 0);
    alloc(1, 0, 1);
    alloc(1, 0, 0);
    chk("R6", "barrier waits", int'(ldok0), 1);
    done(0, 0);
    chk("R6", "barrier oldest", int'(ldok0), 2);
    done(0, 1);
    chk("R6", "younger load after barrier", int'(ldok0), 4);
  endtask

  task automatic t_st_barrier;
    do_reset(1'b1);
    alloc(0, 1, 0);   // st0
    alloc(0, 1, 1);   // st1 barrier
    alloc(0, 1, 0);   // st2
    alloc(1, 0, 0);   // ld0
    chk("R7", "stores", int'(stok0), 1);
    chk("R7", "load not fenced", int'(ldok0), 1);
    done(1, 0);
    chk("R7", "barrier granted", int'(stok0), 2);
    done(1, 1);
    chk("R7", "younger store after barrier", int'(stok0), 4);
  endtask

  task automatic t_full_barrier;
    do_reset(1'b1);
    alloc(1, 0, 0);   // ld0
    alloc(1, 1, 1);   // ld1 + st0
    chk("R8", "fb slots", int'({ld_slot0, st_slot0}), 9);
    alloc(0, 1, 0);   // st1
    alloc(1, 0, 0);   // ld2
    chk("R8", "fb waits ld", int'(ldok0), 1);
    chk("R8", "fb waits st", int'(stok0), 0);
    done(0, 0);
    chk("R8", "fb load half", int'(ldok0), 2);
    chk("R8", "fb store half", int'(stok0), 1);
    done(0, 1);
    chk("R8", "both halves freed ld", int'(ldok0), 4);
    chk("R8", "both halves freed st", int'(stok0), 2);
    chk("R8", "store slot freed", int'(st_slot0), 0);
  endtask

  task automatic t_done_ignored;
    do_reset(1'b1);
    alloc(0, 1, 0);
    alloc(0, 1, 0);
    done(1, 1);
    chk("R11", "no-perm done st_issue", int'(stok0), 1);
    chk("R11", "no-perm done slot", int'(st_slot0), 2);
    done(1, 3);
    chk("R11", "empty done slot", int'(st_slot0), 2);
    done(1, 0);
    chk("R10", "done frees slot", int'(st_slot0), 0);
    chk("R10", "grant moves", int'(stok0), 2);
  endtask

  task automatic t_full;
    do_reset(1'b1);
    for (int k = 0; k < 4; k++) alloc(1, 0, 0);
    chk("R9", "lq full", int'(lqf0), 1);
    chk("R9", "all loads granted", int'(ldok0), 15);
    alloc(1, 0, 0);
    done(0, 2);
    chk("R9", "overflow dropped", int'(ldok0), 11);
    chk("R9", "lq not full", int'(lqf0), 0);
    chk("R9", "lowest free", int'(ld_slot0), 2);
    for (int k = 0; k < 4; k++) alloc(0, 1, 0);
    chk("R9", "sq full", int'(sqf0), 1);
  endtask

  task automatic t_default_depth;
    do_reset(1'b1);
    for (int k = 0; k < 7; k++) alloc(1, 0, 0);
    chk("R12", "default pool not full", int'(lqf1), 0);
    chk("R12", "default slot", int'(ld_slot1), 7);
    alloc(1, 0, 0);
    chk("R12", "default pool full", int'(lqf1), 1);
    chk("R12", "default sq empty", int'(sqf1), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_kinds();
    t_load_pass();
    t_store_order();
    t_relax();
    t_store_between();
    t_ld_barrier();
    t_st_barrier();
    t_full_barrier();
    t_done_ignored();
    t_full();
    t_default_depth();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule